// File: doc/BRIEF.md
# Effective Address Sequencer

This block works out where one instruction operand lives and, when asked, brings it in. It is given a 5-bit addressing-mode code, a register number, an operand size, the current extension word from the prefetch queue and the program counter. It looks up base and index registers through a single read port into a file of sixteen registers: eight data registers at indices 0-7 and eight address registers at indices 8-15. The address and the operand appear on its outputs, together with any address-register update. The bus traffic comes out as one request at a time of kind prefetch, data read or idle, and each request is held until the bus acknowledges it.

There are three operations. A fetch forms the address and reads the operand. A plain address calculation forms the address only. The third is an address calculation that starts with one extra idle cycle, but only for the predecrement mode and the two indexed modes.

The state machine has nine states. IDLE waits for `start` and latches the request. DECODE checks the request and goes to DONE if it is invalid, to PRE_IDLE if a leading idle is owed, and to ADDRESS otherwise. PRE_IDLE issues one idle request and moves to ADDRESS on acknowledge. ADDRESS reads the base register and forms the address or operand. From there the indexed modes go to INDEX, and every other mode goes to PREFETCH, READ or DONE, in that order of preference. INDEX reads the index register and adds it into the address, then goes to PREFETCH. PREFETCH moves on when its last prefetch is acknowledged, going to GAP_IDLE for the indexed modes and otherwise to READ or DONE. GAP_IDLE moves to READ or DONE on acknowledge. READ moves to DONE when its last read is acknowledged. DONE pulses `done` for one cycle and returns to IDLE.

Top module: `eas_seq`

## Requirements
- R1: Mode 0 (data register) and mode 1 (address register) with `op`=0 (fetch) copy the 32-bit register into `operand` with no bus request. Register n reads index n in mode 0 and index 8+n in mode 1.
- R2: Mode 14 (quick) with fetch sets `operand` to `quick_field`, where 0 stands for 8, with no bus request.
- R3: Modes 2 (indirect), 3 (postincrement) and 4 (predecrement) use An as the base. Mode 3 addresses An and writes back An+step. Mode 4 writes back An-step and addresses that value. The step is 1, 2 or 4 for `size` 0 (byte), 1 (word) and 2 (long), except that a byte step on register 7 is 2. The writeback shows on `wb_en`/`wb_reg`/`wb_data` in the done cycle.
- R4: Mode 5 addresses An plus the sign-extended extension word. Mode 7 addresses `pc`-2 plus that word. Both issue one prefetch.
- R5: Modes 6 (An base) and 8 (`pc`-2 base) add an index register and the sign-extended low byte of the extension word. Bits 15:12 of the word choose the index register from 0-15. Bit 11 set uses the whole register; clear uses its sign-extended low 16 bits. The bus sequence is one prefetch, then one idle.
- R6: Mode 9 addresses the sign-extended extension word after one prefetch. Mode 10 addresses {extension word, data of its first prefetch} and issues two prefetches.
- R7: Mode 11 (immediate) with fetch gives the extension word zero-extended to the size, then one prefetch. For long size it gives {extension word, data of the first prefetch} and issues two prefetches.
- R8: A fetch from memory issues, after the address traffic, one read for byte or word size. The result is zero-extended, and only the low byte is kept for byte size. A long fetch issues two reads: the high half from the address and the low half from the address+2.
- R9: `op`=2 adds one idle request before anything else for modes 4, 6 and 8 only. `op`=1 and `op`=2 form the address and issue no read.
- R10: These requests finish with `done` and `err` both high and no bus request: `op`=3, `size`=3, a mode code outside {0-11, 14}, or address-only operations on modes 0, 1, 11 or 14.
- R11: `bus_kind` is 1 for prefetch, 2 for read and 3 for idle. A request keeps its kind and address until `bus_ack`, and the sequence waits while the acknowledge is low.
- R12: `done` is a one-cycle pulse, and `wb_en` is only ever high together with `done`. After reset no request, `done`, `err` or writeback is active and `ea` and `operand` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one operand, sampled in IDLE |
| op | input | 2 | 0 fetch, 1 address only, 2 address with leading idle |
| mode | input | 5 | Addressing-mode code |
| reg_num | input | 3 | Register number from the opcode |
| size | input | 2 | 0 byte, 1 word, 2 long |
| ext_word | input | 16 | Current prefetched extension word |
| pc | input | 32 | Program counter |
| quick_field | input | 3 | Quick data field from the opcode |
| reg_rd_idx | output | 4 | Register file read index |
| reg_rd_data | input | 32 | Register file read data |
| bus_req | output | 1 | Bus request valid |
| bus_kind | output | 2 | Request kind |
| bus_addr | output | 32 | Request address (prefetch or read) |
| bus_ack | input | 1 | Request accepted this cycle |
| bus_rdata | input | 16 | Data returned with the acknowledge |
| ea | output | 32 | Effective address |
| operand | output | 32 | Fetched operand |
| wb_en | output | 1 | Address-register update valid |
| wb_reg | output | 3 | Address register to update |
| wb_data | output | 32 | New address-register value |
| done | output | 1 | Operand finished |
| err | output | 1 | Request was invalid |

## Verification
All results are due in the cycle `done` rises. With a bus that acknowledges at once, that comes 2 clock edges after `start` is taken for an invalid request. For a valid request it comes 3 edges after, plus one per bus request, plus one more for the indexed modes. The bench predicts that edge count for every vector, counts edges at the falling clock until `done`, and compares the count. It samples every result at that same falling edge, and records each acknowledged request kind in order so the whole sequence is compared, not just its length. One stalled run holds the acknowledge low and shows that the request stays put and the finish is pushed back.

// File: rtl/eas_pkg.sv
package eas_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 16;
    localparam int DATA_W  = 2 * WORD_W;
    localparam int MODE_W  = 5;
    localparam int RNUM_W  = 3;
    localparam int RIDX_W  = RNUM_W + 1;
    localparam int QUICK_W = 3;

    localparam logic [MODE_W-1:0] M_DREG  = 5'd0;
    localparam logic [MODE_W-1:0] M_AREG  = 5'd1;
    localparam logic [MODE_W-1:0] M_IND   = 5'd2;
    localparam logic [MODE_W-1:0] M_POST  = 5'd3;
    localparam logic [MODE_W-1:0] M_PRE   = 5'd4;
    localparam logic [MODE_W-1:0] M_D16A  = 5'd5;
    localparam logic [MODE_W-1:0] M_IDXA  = 5'd6;
    localparam logic [MODE_W-1:0] M_D16P  = 5'd7;
    localparam logic [MODE_W-1:0] M_IDXP  = 5'd8;
    localparam logic [MODE_W-1:0] M_ABSW  = 5'd9;
    localparam logic [MODE_W-1:0] M_ABSL  = 5'd10;
    localparam logic [MODE_W-1:0] M_IMM   = 5'd11;
    localparam logic [MODE_W-1:0] M_QUICK = 5'd14;
    localparam logic [MODE_W-1:0] M_LIMIT = 5'd22;

    typedef enum logic [1:0] {OP_FETCH, OP_CALC, OP_CALC_IDLE, OP_RSVD} op_e;
    typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_RSVD} size_e;
    typedef enum logic [1:0] {BK_NONE, BK_PREFETCH, BK_READ, BK_IDLE} kind_e;

    typedef struct packed {
        logic       bad;
        logic       pre_idle;
        logic [1:0] n_pf;
        logic       post_idle;
        logic [1:0] n_rd;
    } plan_t;

    typedef enum logic [3:0] {
        S_IDLE, S_DECODE, S_PRE_IDLE, S_ADDRESS, S_INDEX,
        S_PREFETCH, S_GAP_IDLE, S_READ, S_DONE
    } state_e;
endpackage

// File: rtl/eas_plan.sv
module eas_plan
    import eas_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [1:0]        op,
    input  logic [1:0]        size,
    output plan_t             plan
);
    logic       fetch;
    logic [1:0] reads;

    always_comb begin
        fetch = (op == OP_FETCH);
        reads = fetch ? ((size == SZ_LONG) ? 2'd2 : 2'd1) : 2'd0;
        plan  = '0;
        case (mode)
            M_DREG, M_AREG, M_QUICK: plan.bad = !fetch;
            M_IND, M_POST:           plan.n_rd = reads;
            M_PRE: begin
                plan.n_rd     = reads;
                plan.pre_idle = (op == OP_CALC_IDLE);
            end
            M_D16A, M_D16P, M_ABSW: begin
                plan.n_pf = 2'd1;
                plan.n_rd = reads;
            end
            M_IDXA, M_IDXP: begin
                plan.n_pf      = 2'd1;
                plan.post_idle = 1'b1;
                plan.n_rd      = reads;
                plan.pre_idle  = (op == OP_CALC_IDLE);
            end
            M_ABSL: begin
                plan.n_pf = 2'd2;
                plan.n_rd = reads;
            end
            M_IMM: begin
                plan.bad  = !fetch;
                plan.n_pf = (size == SZ_LONG) ? 2'd2 : 2'd1;
            end
            default: plan.bad = 1'b1;
        endcase
        if (op == OP_RSVD || size == SZ_RSVD || mode >= M_LIMIT) begin
            plan     = '0;
            plan.bad = 1'b1;
        end
    end
endmodule

// File: rtl/eas_arith.sv
module eas_arith
    import eas_pkg::*;
(
    input  logic [MODE_W-1:0]  mode,
    input  logic [1:0]         size,
    input  logic [RNUM_W-1:0]  reg_num,
    input  logic [WORD_W-1:0]  ext,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [DATA_W-1:0]  rd,
    input  logic [ADDR_W-1:0]  base,
    input  logic [QUICK_W-1:0] quick_field,
    output logic [ADDR_W-1:0]  ea_simple,
    output logic [ADDR_W-1:0]  an_next,
    output logic [ADDR_W-1:0]  ea_index,
    output logic [DATA_W-1:0]  quick_val
);
    logic [ADDR_W-1:0] step, sx16, sx8, index;

    always_comb begin
        unique case (size)
            SZ_LONG: step = ADDR_W'(4);
            SZ_WORD: step = ADDR_W'(2);
            default: step = (reg_num == '1) ? ADDR_W'(2) : ADDR_W'(1);
        endcase
        sx16  = {{(ADDR_W-WORD_W){ext[WORD_W-1]}}, ext};
        sx8   = {{(ADDR_W-8){ext[7]}}, ext[7:0]};
        index = ext[11] ? rd : {{(ADDR_W-WORD_W){rd[WORD_W-1]}}, rd[WORD_W-1:0]};
        an_next  = (mode == M_PRE) ? rd - step : rd + step;
        ea_index = base + index + sx8;
        quick_val = (quick_field == '0) ? DATA_W'(8) : DATA_W'(quick_field);
        case (mode)
            M_IND, M_POST: ea_simple = rd;
            M_PRE:         ea_simple = rd - step;
            M_D16A:        ea_simple = rd + sx16;
            M_D16P:        ea_simple = pc - ADDR_W'(2) + sx16;
            M_ABSW:        ea_simple = sx16;
            default:       ea_simple = '0;
        endcase
    end
endmodule

// File: rtl/eas_seq.sv
module eas_seq
    import eas_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [MODE_W-1:0]   mode,
    input  logic [RNUM_W-1:0]   reg_num,
    input  logic [1:0]          size,
    input  logic [WORD_W-1:0]   ext_word,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [QUICK_W-1:0]  quick_field,
    output logic [RIDX_W-1:0]   reg_rd_idx,
    input  logic [DATA_W-1:0]   reg_rd_data,
    output logic                bus_req,
    output logic [1:0]          bus_kind,
    output logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_ack,
    input  logic [WORD_W-1:0]   bus_rdata,
    output logic [ADDR_W-1:0]   ea,
    output logic [DATA_W-1:0]   operand,
    output logic                wb_en,
    output logic [RNUM_W-1:0]   wb_reg,
    output logic [ADDR_W-1:0]   wb_data,
    output logic                done,
    output logic                err
);
    state_e              state, nxt;
    logic [MODE_W-1:0]   mode_q;
    logic [1:0]          op_q, size_q, pf_left, rd_left;
    logic [RNUM_W-1:0]   reg_q;
    logic [WORD_W-1:0]   ext_q;
    logic [ADDR_W-1:0]   pc_q, base_q, ea_q, wb_data_q, pf_addr;
    logic [QUICK_W-1:0]  qf_q;
    logic [DATA_W-1:0]   operand_q, quick_val;
    logic [ADDR_W-1:0]   ea_simple, an_next, ea_index;
    logic                wb_pend, err_q, indexed;
    plan_t               plan;

    eas_plan u_plan (.mode(mode_q), .op(op_q), .size(size_q), .plan(plan));

    eas_arith u_arith (
        .mode(mode_q), .size(size_q), .reg_num(reg_q), .ext(ext_q), .pc(pc_q),
        .rd(reg_rd_data), .base(base_q), .quick_field(qf_q),
        .ea_simple(ea_simple), .an_next(an_next), .ea_index(ea_index), .quick_val(quick_val)
    );

    assign indexed = (mode_q == M_IDXA) || (mode_q == M_IDXP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_DECODE;
            S_DECODE:   nxt = plan.bad ? S_DONE : (plan.pre_idle ? S_PRE_IDLE : S_ADDRESS);
            S_PRE_IDLE: if (bus_ack) nxt = S_ADDRESS;
            S_ADDRESS: begin
                if (indexed)               nxt = S_INDEX;
                else if (plan.n_pf != '0)  nxt = S_PREFETCH;
                else if (plan.n_rd != '0)  nxt = S_READ;
                else                       nxt = S_DONE;
            end
            S_INDEX:    nxt = S_PREFETCH;
            S_PREFETCH: if (bus_ack && pf_left == 2'd1)
                            nxt = plan.post_idle ? S_GAP_IDLE
                                : ((plan.n_rd != '0) ? S_READ : S_DONE);
            S_GAP_IDLE: if (bus_ack) nxt = (plan.n_rd != '0) ? S_READ : S_DONE;
            S_READ:     if (bus_ack && rd_left == 2'd1) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; op_q <= '0; size_q <= '0; reg_q <= '0; ext_q <= '0;
            pc_q <= '0; qf_q <= '0; base_q <= '0; ea_q <= '0; operand_q <= '0;
            wb_pend <= 1'b0; wb_data_q <= '0; err_q <= 1'b0;
            pf_left <= '0; rd_left <= '0; pf_addr <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    mode_q <= mode; op_q <= op; size_q <= size; reg_q <= reg_num;
                    ext_q <= ext_word; pc_q <= pc; qf_q <= quick_field;
                    ea_q <= '0; operand_q <= '0; wb_pend <= 1'b0; err_q <= 1'b0;
                end
                S_DECODE: err_q <= plan.bad;
                S_ADDRESS: begin
                    case (mode_q)
                        M_DREG, M_AREG: operand_q <= reg_rd_data;
                        M_QUICK:        operand_q <= quick_val;
                        M_IMM: if (size_q != SZ_LONG)
                                   operand_q <= (size_q == SZ_BYTE) ? DATA_W'(ext_q[7:0])
                                                                    : DATA_W'(ext_q);
                        M_IDXA:         base_q <= reg_rd_data;
                        M_IDXP:         base_q <= pc_q - ADDR_W'(2);
                        default:        ea_q <= ea_simple;
                    endcase
                    if (mode_q == M_POST || mode_q == M_PRE) begin
                        wb_pend   <= 1'b1;
                        wb_data_q <= an_next;
                    end
                    pf_left <= plan.n_pf;
                    rd_left <= plan.n_rd;
                    pf_addr <= pc_q;
                end
                S_INDEX: ea_q <= ea_index;
                S_PREFETCH: if (bus_ack) begin
                    pf_left <= pf_left - 2'd1;
                    pf_addr <= pf_addr + ADDR_W'(2);
                    if (pf_left == 2'd2) begin
                        if (mode_q == M_ABSL) ea_q      <= {ext_q, bus_rdata};
                        else                  operand_q <= {ext_q, bus_rdata};
                    end
                end
                S_READ: if (bus_ack) begin
                    rd_left <= rd_left - 2'd1;
                    if (size_q == SZ_LONG) begin
                        if (rd_left == 2'd2) operand_q[DATA_W-1:WORD_W] <= bus_rdata;
                        else                 operand_q[WORD_W-1:0]      <= bus_rdata;
                    end else begin
                        operand_q <= (size_q == SZ_BYTE) ? DATA_W'(bus_rdata[7:0])
                                                         : DATA_W'(bus_rdata);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_req  = 1'b0;
        bus_kind = BK_NONE;
        bus_addr = '0;
        unique case (state)
            S_PRE_IDLE, S_GAP_IDLE: begin
                bus_req = 1'b1; bus_kind = BK_IDLE;
            end
            S_PREFETCH: begin
                bus_req = 1'b1; bus_kind = BK_PREFETCH; bus_addr = pf_addr;
            end
            S_READ: begin
                bus_req  = 1'b1; bus_kind = BK_READ;
                bus_addr = (size_q == SZ_LONG && rd_left == 2'd1) ? ea_q + ADDR_W'(2) : ea_q;
            end
            default: ;
        endcase
        reg_rd_idx = (state == S_INDEX) ? ext_q[WORD_W-1 -: RIDX_W]
                                        : {mode_q != M_DREG, reg_q};
        done    = (state == S_DONE);
        err     = done && err_q;
        wb_en   = done && wb_pend;
        wb_reg  = reg_q;
        wb_data = wb_data_q;
        ea      = ea_q;
        operand = operand_q;
    end
endmodule

// File: rtl/eas_seq_chk.sv
module eas_seq_chk
    import eas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [1:0]        bus_kind,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic              err,
    input logic              wb_en
);
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_kind) && $stable(bus_addr));

    p_kind_named_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_kind != 2'd0);

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !bus_req);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_wb_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
endmodule

bind eas_seq eas_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_kind(bus_kind), .bus_addr(bus_addr), .done(done), .err(err), .wb_en(wb_en)
);

// File: tb/tb_eas_seq.sv
module tb_eas_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0, size = '0;
    logic [4:0]  mode = '0;
    logic [2:0]  reg_num = '0, quick_field = '0;
    logic [15:0] ext_word = '0;
    logic [31:0] pc = 32'h0000_4000;
    logic [3:0]  reg_rd_idx;
    logic [31:0] reg_rd_data;
    logic        bus_req, bus_ack, ack_en = 1'b1;
    logic [1:0]  bus_kind;
    logic [31:0] bus_addr, ea, operand, wb_data;
    logic [15:0] bus_rdata;
    logic        wb_en, done, err;
    logic [2:0]  wb_reg;

    int vectors = 0, miscompares = 0, bus_total = 0;
    logic [15:0] trace = '0;

    always #5 clk = ~clk;

    eas_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .reg_num(reg_num),
        .size(size), .ext_word(ext_word), .pc(pc), .quick_field(quick_field),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .bus_req(bus_req),
        .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .ea(ea), .operand(operand), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .done(done), .err(err)
    );

    function automatic logic [31:0] rf(input logic [3:0] i);
        return 32'h0011_0000 * i + (i[0] ? 32'h0000_8010 : 32'h0000_0120);
    endfunction
    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction
    function automatic logic [15:0] pff(input logic [31:0] a);
        return a[15:0] ^ 16'hC3C3;
    endfunction

    assign reg_rd_data = rf(reg_rd_idx);
    assign bus_ack     = bus_req && ack_en;
    assign bus_rdata   = (bus_kind == 2'd1) ? pff(bus_addr) : memf(bus_addr);

    always @(posedge clk) begin
        if (bus_req && bus_ack) begin
            trace     <= {trace[13:0], bus_kind};
            bus_total <= bus_total + 1;
        end
    end

    // expected results
    logic        e_err, e_wb;
    logic [31:0] e_ea, e_opnd, e_wbd;
    logic [15:0] e_seq;
    int          e_n, e_lat;
    string       e_tag;

    task automatic push(input logic [1:0] k);
        e_seq = {e_seq[13:0], k};
        e_n++;
    endtask

    task automatic model(input logic [4:0] m, input logic [1:0] o, input logic [1:0] s,
                         input logic [2:0] r, input logic [15:0] x);
        logic [31:0] inc, an, sx16, sx8, xi, bse;
        logic [15:0] w;
        int rdn, idx;
        bit bad;
        e_err = 0; e_ea = 0; e_opnd = 0; e_wb = 0; e_wbd = 0; e_seq = 0; e_n = 0; idx = 0;
        e_tag = "R8";
        bad = (o == 2'd3) || (s == 2'd3) || !(m <= 5'd11 || m == 5'd14) ||
              (o != 2'd0 && (m == 5'd0 || m == 5'd1 || m == 5'd11 || m == 5'd14));
        if (bad) begin
            e_err = 1; e_lat = 2; e_tag = "R10";
            return;
        end
        inc  = (s == 2'd2) ? 4 : (s == 2'd1) ? 2 : ((r == 3'd7) ? 2 : 1);
        an   = rf({1'b1, r});
        sx16 = {{16{x[15]}}, x};
        sx8  = {{24{x[7]}}, x[7:0]};
        rdn  = (o == 2'd0) ? ((s == 2'd2) ? 2 : 1) : 0;
        if (o == 2'd2 && (m == 5'd4 || m == 5'd6 || m == 5'd8)) push(2'd3);
        case (m)
            5'd0:  begin e_opnd = rf({1'b0, r}); rdn = 0; e_tag = "R1"; end
            5'd1:  begin e_opnd = an; rdn = 0; e_tag = "R1"; end
            5'd14: begin e_opnd = (quick_field == 0) ? 8 : {29'd0, quick_field}; rdn = 0; e_tag = "R2"; end
            5'd2:  begin e_ea = an; e_tag = "R3"; end
            5'd3:  begin e_ea = an; e_wb = 1; e_wbd = an + inc; e_tag = "R3"; end
            5'd4:  begin e_ea = an - inc; e_wb = 1; e_wbd = an - inc; e_tag = "R3"; end
            5'd5:  begin e_ea = an + sx16; push(2'd1); e_tag = "R4"; end
            5'd7:  begin e_ea = pc - 2 + sx16; push(2'd1); e_tag = "R4"; end
            5'd6, 5'd8: begin
                bse = (m == 5'd6) ? an : pc - 2;
                xi  = rf(x[15:12]);
                if (!x[11]) xi = {{16{xi[15]}}, xi[15:0]};
                e_ea = bse + xi + sx8; push(2'd1); push(2'd3); idx = 1; e_tag = "R5";
            end
            5'd9:  begin e_ea = sx16; push(2'd1); e_tag = "R6"; end
            5'd10: begin e_ea = {x, pff(pc)}; push(2'd1); push(2'd1); e_tag = "R6"; end
            default: begin
                rdn = 0; e_tag = "R7";
                if (s == 2'd2) begin e_opnd = {x, pff(pc)}; push(2'd1); push(2'd1); end
                else begin e_opnd = (s == 2'd0) ? {24'd0, x[7:0]} : {16'd0, x}; push(2'd1); end
            end
        endcase
        if (rdn == 2) begin
            e_opnd = {memf(e_ea), memf(e_ea + 2)}; push(2'd2); push(2'd2);
        end else if (rdn == 1) begin
            w = memf(e_ea);
            e_opnd = (s == 2'd0) ? {24'd0, w[7:0]} : {16'd0, w}; push(2'd2);
        end
        if (o == 2'd2) e_tag = "R9";
        e_lat = 3 + e_n + idx;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_checks(input int cnt, input int base, input logic [2:0] r);
        int n;
        logic [15:0] msk;
        n   = bus_total - base;
        msk = 16'((32'd1 << (2 * e_n)) - 1);
        chk(done === 1'b1 && cnt == e_lat, e_tag, "latency", cnt, e_lat);
        chk(err === e_err, e_tag, "err", {31'd0, err}, {31'd0, e_err});
        chk(ea === e_ea, e_tag, "ea", ea, e_ea);
        chk(operand === e_opnd, e_tag, "operand", operand, e_opnd);
        chk(wb_en === e_wb, "R3", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
        if (e_wb) chk(wb_data === e_wbd && wb_reg === r, "R3", "wb_data", wb_data, e_wbd);
        chk(n == e_n, "R11", "bus count", n, e_n);
        chk((trace & msk) === e_seq, e_tag, "bus sequence", {16'd0, trace & msk}, {16'd0, e_seq});
        @(negedge clk);
        chk(done === 1'b0 && wb_en === 1'b0, "R12", "done pulse", {31'd0, done}, 0);
    endtask

    task automatic run(input logic [4:0] m, input logic [1:0] o, input logic [1:0] s,
                       input logic [2:0] r, input logic [15:0] x);
        int cnt, base;
        model(m, o, s, r, x);
        @(negedge clk);
        mode = m; op = o; size = s; reg_num = r; ext_word = x; start = 1'b1;
        base = bus_total;
        cnt = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end while (!done && cnt < 64);
        finish_checks(cnt, base, r);
    endtask

    // {mode, op, size, reg, ext}
    localparam logic [27:0] VEC [0:27] = '{
        {5'd0,  2'd0, 2'd2, 3'd3, 16'h0000},
        {5'd1,  2'd0, 2'd1, 3'd5, 16'h0000},
        {5'd2,  2'd0, 2'd1, 3'd2, 16'h0000},
        {5'd2,  2'd0, 2'd2, 3'd2, 16'h0000},
        {5'd3,  2'd0, 2'd0, 3'd3, 16'h0000},
        {5'd3,  2'd0, 2'd0, 3'd7, 16'h0000},
        {5'd3,  2'd0, 2'd2, 3'd1, 16'h0000},
        {5'd4,  2'd0, 2'd1, 3'd4, 16'h0000},
        {5'd4,  2'd2, 2'd0, 3'd7, 16'h0000},
        {5'd5,  2'd0, 2'd1, 3'd0, 16'hFFF0},
        {5'd7,  2'd0, 2'd2, 3'd0, 16'h0010},
        {5'd6,  2'd0, 2'd0, 3'd6, 16'h30F8},
        {5'd8,  2'd2, 2'd1, 3'd0, 16'hB804},
        {5'd6,  2'd1, 2'd2, 3'd1, 16'h9802},
        {5'd9,  2'd0, 2'd1, 3'd0, 16'h8000},
        {5'd10, 2'd0, 2'd2, 3'd0, 16'h0012},
        {5'd10, 2'd1, 2'd1, 3'd0, 16'h0034},
        {5'd11, 2'd0, 2'd0, 3'd0, 16'h12AB},
        {5'd11, 2'd0, 2'd2, 3'd0, 16'h7788},
        {5'd11, 2'd0, 2'd1, 3'd0, 16'hBEEF},
        {5'd5,  2'd2, 2'd1, 3'd2, 16'h0100},
        {5'd4,  2'd1, 2'd2, 3'd2, 16'h0000},
        {5'd12, 2'd0, 2'd1, 3'd0, 16'h0000},
        {5'd0,  2'd1, 2'd2, 3'd0, 16'h0000},
        {5'd2,  2'd0, 2'd3, 3'd0, 16'h0000},
        {5'd2,  2'd3, 2'd1, 3'd0, 16'h0000},
        {5'd22, 2'd0, 2'd1, 3'd0, 16'h0000},
        {5'd14, 2'd1, 2'd1, 3'd0, 16'h0000}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!done && !err && !wb_en && !bus_req && ea == 0 && operand == 0,
            "R12", "reset state", {27'd0, done, err, wb_en, bus_req, 1'b0}, 0);

        for (int i = 0; i < 28; i++) begin
            run(VEC[i][27:23], VEC[i][22:21], VEC[i][20:19], VEC[i][18:16], VEC[i][15:0]);
        end

        // R2: quick field, 0 stands for 8
        quick_field = 3'd0;
        run(5'd14, 2'd0, 2'd2, 3'd0, 16'h0000);
        quick_field = 3'd5;
        run(5'd14, 2'd0, 2'd1, 3'd0, 16'h0000);

        // R11: stalled acknowledge on a word read through (A2)
        begin
            int base;
            model(5'd2, 2'd0, 2'd1, 3'd2, 16'h0000);
            ack_en = 1'b0;
            @(negedge clk);
            mode = 5'd2; op = 2'd0; size = 2'd1; reg_num = 3'd2; ext_word = '0; start = 1'b1;
            base = bus_total;
            repeat (6) begin
                @(negedge clk);
                start = 1'b0;
            end
            chk(bus_req === 1'b1 && bus_kind === 2'd2 && bus_addr === e_ea && !done,
                "R11", "held request", bus_addr, e_ea);
            ack_en = 1'b1;
            e_lat = 7;
            @(negedge clk);
            finish_checks(7, base, 3'd2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule